// File: doc/BRIEF.md
# Interrupt Entry Stacking Sequencer

This block saves the processor register set to a byte-wide stack in memory when an interrupt or trap is taken, and restores it on return from the handler. An entry command snapshots the program counter, both index registers, both accumulators and the condition-code byte. The sequencer then writes them one byte per clock toward lower addresses, starting at the current stack pointer. A return command reads the same nine bytes back in the opposite order, starting just above the stack pointer, and presents the restored registers and stack pointer at its outputs.

When the trap input flags an illegal opcode, the return address that is pushed is the supplied address of the faulting instruction's first byte, and the ordinary program counter is not used. If the faulting instruction began with a prebyte, that address is the prebyte's address. The sequencer pulses a flag in the cycle the condition-code byte is written, so that the surrounding control can update its mask bits on that event. Memory reads are combinational: read data for the address driven in a cycle must be valid in that same cycle.

Top module: `irq_stack_seq`

## Requirements
- R1: An entry writes nine bytes in nine consecutive cycles, starting the cycle after the command. Byte k (k = 0..8) goes to address SP-k, and the bytes in order are PC low, PC high, IY low, IY high, IX low, IX high, accumulator A, accumulator B, condition code. The values are those present at the ports in the command cycle.
- R2: When the trap flag is high with an entry command, the pushed PC bytes are the first-byte address input, used unchanged even where that byte is a prebyte. Otherwise they are the PC input.
- R3: `ccr_stacked` is high only in the cycle in which the condition-code byte is written.
- R4: After an entry completes, `sp_out` equals the starting SP minus 9, modulo 2^16.
- R5: A return reads nine bytes in nine consecutive cycles from addresses SP+1 to SP+9, in the order condition code, B, A, IX high, IX low, IY high, IY low, PC high, PC low. After the return, the restored register outputs hold those bytes.
- R6: After a return completes, `sp_out` equals the supplied SP plus 9, modulo 2^16.
- R7: At most one of `mem_we` and `mem_re` is high in any cycle. Both are low while `busy` is low, and `busy` is high in exactly the nine transfer cycles of an operation.
- R8: An entry or return command that arrives while `busy` is high, including in the last transfer cycle, is ignored.
- R9: If entry and return commands arrive together while idle, the entry is performed.
- R10: After reset, `busy`, `done`, `ccr_stacked`, `mem_we` and `mem_re` are low, and `sp_out` and all restored register outputs are zero.
- R11: `done` is high only in the last transfer cycle of an operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| entry_req | input | 1 | Start an entry (push) sequence |
| return_req | input | 1 | Start a return (pull) sequence |
| trap_illegal | input | 1 | Entry is an illegal-opcode trap |
| sp_in | input | 16 | Current stack pointer |
| pc_in | input | 16 | Return address for normal interrupts |
| bad_pc_in | input | 16 | Address of first byte of faulting instruction |
| iy_in | input | 16 | IY register |
| ix_in | input | 16 | IX register |
| acc_a_in | input | 8 | Accumulator A |
| acc_b_in | input | 8 | Accumulator B |
| ccr_in | input | 8 | Condition-code byte |
| mem_addr | output | 16 | Stack memory address |
| mem_wdata | output | 8 | Write data |
| mem_we | output | 1 | Write strobe |
| mem_re | output | 1 | Read strobe |
| mem_rdata | input | 8 | Read data, valid in the same cycle |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | Last transfer cycle |
| ccr_stacked | output | 1 | Condition-code byte written this cycle |
| sp_out | output | 16 | Updated stack pointer |
| pc_out | output | 16 | Restored PC |
| iy_out | output | 16 | Restored IY |
| ix_out | output | 16 | Restored IX |
| acc_a_out | output | 8 | Restored accumulator A |
| acc_b_out | output | 8 | Restored accumulator B |
| ccr_out | output | 8 | Restored condition code |

## Verification
Two pairs of events can land in one cycle. First, a new command can arrive in the final transfer cycle, while the operation finishes and `done` is high. Second, entry and return commands can both arrive while the block is idle. The bench raises a command in the last cycle of both entry and return sequences, and confirms that no access appears in the following cycle and that the stack pointer reflects only the finished operation. It also raises both commands together from idle, and confirms that nine writes follow and no reads.

// File: rtl/irq_stack_pkg.sv
package irq_stack_pkg;
    localparam int FRAME_BYTES = 9;
    localparam int STEP_W      = $clog2(FRAME_BYTES);

    // byte slots of the saved frame, slot k lives at SP-k
    localparam int SLOT_PCL = 0;
    localparam int SLOT_PCH = 1;
    localparam int SLOT_IYL = 2;
    localparam int SLOT_IYH = 3;
    localparam int SLOT_IXL = 4;
    localparam int SLOT_IXH = 5;
    localparam int SLOT_A   = 6;
    localparam int SLOT_B   = 7;
    localparam int SLOT_CCR = 8;

    typedef enum logic {
        DIR_PUSH = 1'b0,
        DIR_PULL = 1'b1
    } dir_e;
endpackage

// File: rtl/irq_frame_pack.sv
module irq_frame_pack
    import irq_stack_pkg::*;
#(
    parameter int DATA_W = 8,
    localparam int WORD_W = 2 * DATA_W
) (
    input  logic                                   trap_illegal,
    input  logic [WORD_W-1:0]                      pc_in,
    input  logic [WORD_W-1:0]                      bad_pc_in,
    input  logic [WORD_W-1:0]                      iy_in,
    input  logic [WORD_W-1:0]                      ix_in,
    input  logic [DATA_W-1:0]                      acc_a_in,
    input  logic [DATA_W-1:0]                      acc_b_in,
    input  logic [DATA_W-1:0]                      ccr_in,
    output logic [FRAME_BYTES-1:0][DATA_W-1:0]     frame
);
    logic [WORD_W-1:0] ret_addr;

    // illegal-opcode trap stacks the first byte of the bad instruction
    assign ret_addr = trap_illegal ? bad_pc_in : pc_in;

    always_comb begin
        frame           = '0;
        frame[SLOT_PCL] = ret_addr[DATA_W-1:0];
        frame[SLOT_PCH] = ret_addr[WORD_W-1:DATA_W];
        frame[SLOT_IYL] = iy_in[DATA_W-1:0];
        frame[SLOT_IYH] = iy_in[WORD_W-1:DATA_W];
        frame[SLOT_IXL] = ix_in[DATA_W-1:0];
        frame[SLOT_IXH] = ix_in[WORD_W-1:DATA_W];
        frame[SLOT_A]   = acc_a_in;
        frame[SLOT_B]   = acc_b_in;
        frame[SLOT_CCR] = ccr_in;
    end
endmodule

// File: rtl/irq_frame_unpack.sv
module irq_frame_unpack
    import irq_stack_pkg::*;
#(
    parameter int DATA_W = 8,
    localparam int WORD_W = 2 * DATA_W
) (
    input  logic [FRAME_BYTES-1:0][DATA_W-1:0] frame,
    output logic [WORD_W-1:0]                  pc_out,
    output logic [WORD_W-1:0]                  iy_out,
    output logic [WORD_W-1:0]                  ix_out,
    output logic [DATA_W-1:0]                  acc_a_out,
    output logic [DATA_W-1:0]                  acc_b_out,
    output logic [DATA_W-1:0]                  ccr_out
);
    assign pc_out    = {frame[SLOT_PCH], frame[SLOT_PCL]};
    assign iy_out    = {frame[SLOT_IYH], frame[SLOT_IYL]};
    assign ix_out    = {frame[SLOT_IXH], frame[SLOT_IXL]};
    assign acc_a_out = frame[SLOT_A];
    assign acc_b_out = frame[SLOT_B];
    assign ccr_out   = frame[SLOT_CCR];
endmodule

// File: rtl/irq_addr_gen.sv
module irq_addr_gen
    import irq_stack_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic [ADDR_W-1:0] sp_base,
    input  logic [STEP_W-1:0] step,
    input  dir_e              dir,
    output logic [ADDR_W-1:0] addr
);
    logic [ADDR_W-1:0] step_ext;

    assign step_ext = ADDR_W'(step);

    // push walks down from SP, pull walks up from SP+1
    always_comb begin
        if (dir == DIR_PUSH) addr = sp_base - step_ext;
        else                 addr = sp_base + step_ext + ADDR_W'(1);
    end
endmodule

// File: rtl/irq_stack_seq.sv
module irq_stack_seq
    import irq_stack_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8,
    localparam int WORD_W = 2 * DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              entry_req,
    input  logic              return_req,
    input  logic              trap_illegal,
    input  logic [ADDR_W-1:0] sp_in,
    input  logic [WORD_W-1:0] pc_in,
    input  logic [WORD_W-1:0] bad_pc_in,
    input  logic [WORD_W-1:0] iy_in,
    input  logic [WORD_W-1:0] ix_in,
    input  logic [DATA_W-1:0] acc_a_in,
    input  logic [DATA_W-1:0] acc_b_in,
    input  logic [DATA_W-1:0] ccr_in,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              mem_we,
    output logic              mem_re,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              busy,
    output logic              done,
    output logic              ccr_stacked,
    output logic [ADDR_W-1:0] sp_out,
    output logic [WORD_W-1:0] pc_out,
    output logic [WORD_W-1:0] iy_out,
    output logic [WORD_W-1:0] ix_out,
    output logic [DATA_W-1:0] acc_a_out,
    output logic [DATA_W-1:0] acc_b_out,
    output logic [DATA_W-1:0] ccr_out
);
    localparam logic [STEP_W-1:0] LAST_STEP  = STEP_W'(FRAME_BYTES - 1);
    localparam logic [ADDR_W-1:0] FRAME_SPAN = ADDR_W'(FRAME_BYTES);

    typedef struct packed {
        logic                              busy;
        dir_e                              dir;
        logic [STEP_W-1:0]                 step;
        logic [ADDR_W-1:0]                 sp;
        logic [FRAME_BYTES-1:0][DATA_W-1:0] frame;
    } seq_t;

    seq_t seq_d, seq_q;

    logic [FRAME_BYTES-1:0][DATA_W-1:0] snap_frame;
    logic [STEP_W-1:0]                  pull_slot;
    logic                               last_xfer;
    logic [ADDR_W-1:0]                  xfer_addr;

    irq_frame_pack #(.DATA_W(DATA_W)) u_pack (
        .trap_illegal (trap_illegal),
        .pc_in        (pc_in),
        .bad_pc_in    (bad_pc_in),
        .iy_in        (iy_in),
        .ix_in        (ix_in),
        .acc_a_in     (acc_a_in),
        .acc_b_in     (acc_b_in),
        .ccr_in       (ccr_in),
        .frame        (snap_frame)
    );

    irq_addr_gen #(.ADDR_W(ADDR_W)) u_addr (
        .sp_base (seq_q.sp),
        .step    (seq_q.step),
        .dir     (seq_q.dir),
        .addr    (xfer_addr)
    );

    irq_frame_unpack #(.DATA_W(DATA_W)) u_unpack (
        .frame     (seq_q.frame),
        .pc_out    (pc_out),
        .iy_out    (iy_out),
        .ix_out    (ix_out),
        .acc_a_out (acc_a_out),
        .acc_b_out (acc_b_out),
        .ccr_out   (ccr_out)
    );

    assign pull_slot = LAST_STEP - seq_q.step;
    assign last_xfer = seq_q.busy && (seq_q.step == LAST_STEP);

    always_comb begin
        seq_d = seq_q;
        if (!seq_q.busy) begin
            // entry takes precedence over return when both are raised
            if (entry_req) begin
                seq_d.busy  = 1'b1;
                seq_d.dir   = DIR_PUSH;
                seq_d.step  = '0;
                seq_d.sp    = sp_in;
                seq_d.frame = snap_frame;
            end else if (return_req) begin
                seq_d.busy = 1'b1;
                seq_d.dir  = DIR_PULL;
                seq_d.step = '0;
                seq_d.sp   = sp_in;
            end
        end else begin
            if (seq_q.dir == DIR_PULL) begin
                seq_d.frame[pull_slot] = mem_rdata;
            end
            if (last_xfer) begin
                seq_d.busy = 1'b0;
                seq_d.step = '0;
                seq_d.sp   = (seq_q.dir == DIR_PUSH) ? seq_q.sp - FRAME_SPAN
                                                     : seq_q.sp + FRAME_SPAN;
            end else begin
                seq_d.step = seq_q.step + STEP_W'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) seq_q <= '0;
        else        seq_q <= seq_d;
    end

    assign busy        = seq_q.busy;
    assign done        = last_xfer;
    assign mem_we      = seq_q.busy && (seq_q.dir == DIR_PUSH);
    assign mem_re      = seq_q.busy && (seq_q.dir == DIR_PULL);
    assign mem_addr    = seq_q.busy ? xfer_addr : '0;
    assign mem_wdata   = mem_we ? seq_q.frame[seq_q.step] : '0;
    assign ccr_stacked = mem_we && last_xfer;
    assign sp_out      = seq_q.sp;
endmodule

// File: rtl/irq_stack_seq_chk.sv
module irq_stack_seq_chk #(
    parameter int ADDR_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              entry_req,
    input logic              return_req,
    input logic              busy,
    input logic              done,
    input logic              ccr_stacked,
    input logic              mem_we,
    input logic              mem_re,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [ADDR_W-1:0] sp_out
);
    logic [3:0] xfer_cnt;

    always_ff @(posedge clk) begin
        if (!rst_n)    xfer_cnt <= '0;
        else if (busy) xfer_cnt <= xfer_cnt + 4'd1;
        else           xfer_cnt <= '0;
    end

    assert_single_access_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_we && mem_re));

    assert_idle_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!mem_we && !mem_re));

    assert_start_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && (entry_req || return_req)) |=> busy);

    assert_nine_xfers_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (xfer_cnt == 4'd8));

    assert_push_descend_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && $past(mem_we)) |-> (mem_addr == $past(mem_addr) - ADDR_W'(1)));

    assert_pull_ascend_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_re && $past(mem_re)) |-> (mem_addr == $past(mem_addr) + ADDR_W'(1)));

    assert_ccr_flag_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ccr_stacked |-> (mem_we && done));

    assert_hold_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> busy);

    assert_end_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy);

    assert_sp_entry_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (done && mem_we) |=> (sp_out == $past(mem_addr) - ADDR_W'(1)));

    assert_sp_return_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (done && mem_re) |=> (sp_out == $past(mem_addr)));

    assert_entry_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && entry_req && return_req) |=> mem_we);
endmodule

bind irq_stack_seq irq_stack_seq_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .entry_req   (entry_req),
    .return_req  (return_req),
    .busy        (busy),
    .done        (done),
    .ccr_stacked (ccr_stacked),
    .mem_we      (mem_we),
    .mem_re      (mem_re),
    .mem_addr    (mem_addr),
    .sp_out      (sp_out)
);

// File: tb/irq_stack_seq_test.sv
module irq_stack_seq_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        entry_req = 1'b0, return_req = 1'b0, trap_illegal = 1'b0;
    logic [15:0] sp_in = '0, pc_in = '0, bad_pc_in = '0, iy_in = '0, ix_in = '0;
    logic [7:0]  acc_a_in = '0, acc_b_in = '0, ccr_in = '0;
    logic [15:0] mem_addr, sp_out, pc_out, iy_out, ix_out;
    logic [7:0]  mem_wdata, mem_rdata, acc_a_out, acc_b_out, ccr_out;
    logic        mem_we, mem_re, busy, done, ccr_stacked;

    logic [7:0]  bmem [0:255];
    int          checks = 0;
    int          failures = 0;
    bit          finished = 1'b0;

    always #2 clk = ~clk;

    irq_stack_seq uut (
        .clk(clk), .rst_n(rst_n), .entry_req(entry_req), .return_req(return_req),
        .trap_illegal(trap_illegal), .sp_in(sp_in), .pc_in(pc_in), .bad_pc_in(bad_pc_in),
        .iy_in(iy_in), .ix_in(ix_in), .acc_a_in(acc_a_in), .acc_b_in(acc_b_in),
        .ccr_in(ccr_in), .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_we(mem_we),
        .mem_re(mem_re), .mem_rdata(mem_rdata), .busy(busy), .done(done),
        .ccr_stacked(ccr_stacked), .sp_out(sp_out), .pc_out(pc_out), .iy_out(iy_out),
        .ix_out(ix_out), .acc_a_out(acc_a_out), .acc_b_out(acc_b_out), .ccr_out(ccr_out)
    );

    assign mem_rdata = bmem[mem_addr[7:0]];
    always @(posedge clk) if (mem_we) bmem[mem_addr[7:0]] <= mem_wdata;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // expected content of frame slot k (slot k sits at SP-k)
    function automatic logic [7:0] slot_byte(input int k, input logic [15:0] pcv,
        input logic [15:0] iy, input logic [15:0] ix, input logic [7:0] a,
        input logic [7:0] b, input logic [7:0] c);
        case (k)
            0: return pcv[7:0];
            1: return pcv[15:8];
            2: return iy[7:0];
            3: return iy[15:8];
            4: return ix[7:0];
            5: return ix[15:8];
            6: return a;
            7: return b;
            default: return c;
        endcase
    endfunction

    task automatic do_entry(input logic [15:0] sp, input logic [15:0] pc, input logic [15:0] bad,
        input bit trap, input logic [15:0] iy, input logic [15:0] ix, input logic [7:0] a,
        input logic [7:0] b, input logic [7:0] c, input bit both, input bit late);
        logic [15:0] pcv;
        pcv = trap ? bad : pc;
        @(negedge clk);
        sp_in = sp; pc_in = pc; bad_pc_in = bad; trap_illegal = trap;
        iy_in = iy; ix_in = ix; acc_a_in = a; acc_b_in = b; ccr_in = c;
        entry_req = 1'b1; return_req = both;
        for (int i = 0; i < 9; i++) begin
            @(negedge clk);
            chk("R7 busy during push", busy, 1);
            chk("R1/R9 write strobe", {mem_we, mem_re}, 2'b10);
            chk("R1 push address", mem_addr, 16'(sp - 16'(i)));
            chk("R1/R2 push data", mem_wdata, slot_byte(i, pcv, iy, ix, a, b, c));
            chk("R3 ccr_stacked", ccr_stacked, (i == 8));
            chk("R11 done", done, (i == 8));
            entry_req = 1'b0; return_req = 1'b0;
            // scramble inputs after capture; R8 late commands
            sp_in = 16'($urandom); pc_in = 16'($urandom); bad_pc_in = 16'($urandom);
            iy_in = 16'($urandom); ccr_in = 8'($urandom);
            if (late && i == 4) return_req = 1'b1;
            if (late && i == 8) entry_req = 1'b1;
        end
        @(negedge clk);
        chk("R8 no access after push", {busy, mem_we, mem_re}, 3'b000);
        chk("R4 sp after entry", sp_out, 16'(sp - 16'd9));
        entry_req = 1'b0; return_req = 1'b0;
        for (int k = 0; k < 9; k++)
            chk("R1 stored byte", bmem[8'(sp - 16'(k))], slot_byte(k, pcv, iy, ix, a, b, c));
    endtask

    task automatic do_return(input logic [15:0] sp, input logic [15:0] pcv,
        input logic [15:0] iy, input logic [15:0] ix, input logic [7:0] a,
        input logic [7:0] b, input logic [7:0] c, input bit late);
        @(negedge clk);
        sp_in = sp; return_req = 1'b1;
        for (int i = 0; i < 9; i++) begin
            @(negedge clk);
            chk("R7 busy during pull", busy, 1);
            chk("R5 read strobe", {mem_we, mem_re}, 2'b01);
            chk("R5 pull address", mem_addr, 16'(sp + 16'd1 + 16'(i)));
            chk("R11 done", done, (i == 8));
            return_req = 1'b0;
            sp_in = 16'($urandom);
            if (late && i == 8) begin entry_req = 1'b1; return_req = 1'b1; end
        end
        @(negedge clk);
        chk("R8 no access after pull", {busy, mem_we, mem_re}, 3'b000);
        chk("R6 sp after return", sp_out, 16'(sp + 16'd9));
        chk("R5 restored pc", pc_out, pcv);
        chk("R5 restored iy", iy_out, iy);
        chk("R5 restored ix", ix_out, ix);
        chk("R5 restored a/b/ccr", {acc_a_out, acc_b_out, ccr_out}, {a, b, c});
        entry_req = 1'b0; return_req = 1'b0;
    endtask

    task automatic round(input logic [15:0] sp, input bit trap, input bit both, input bit late);
        logic [15:0] pc, bad, iy, ix;
        logic [7:0]  a, b, c;
        pc = 16'($urandom); bad = 16'($urandom); iy = 16'($urandom); ix = 16'($urandom);
        a = 8'($urandom); b = 8'($urandom); c = 8'($urandom);
        do_entry(sp, pc, bad, trap, iy, ix, a, b, c, both, late);
        do_return(16'(sp - 16'd9), trap ? bad : pc, iy, ix, a, b, c, late);
    endtask

    initial begin
        #800000;
        if (!finished) begin
            failures++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        for (int i = 0; i < 256; i++) bmem[i] = 8'h00;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10 reset state
        chk("R10 reset flags", {busy, done, ccr_stacked, mem_we, mem_re}, 5'b0);
        chk("R10 reset sp", sp_out, 16'h0000);
        chk("R10 reset regs", {pc_out, iy_out, ix_out}, 48'h0);
        chk("R10 reset bytes", {acc_a_out, acc_b_out, ccr_out}, 24'h0);

        // directed: normal interrupt, R2 trap with prebyte address, wrap cases
        do_entry(16'h01F0, 16'h1234, 16'hBEEF, 1'b0, 16'h5566, 16'h7788, 8'h9A, 8'hBC, 8'hD0, 1'b0, 1'b0);
        do_return(16'h01E7, 16'h1234, 16'h5566, 16'h7788, 8'h9A, 8'hBC, 8'hD0, 1'b0);
        // R2: bad_pc points at a prebyte; pushed unchanged
        do_entry(16'h0080, 16'hC003, 16'hC000, 1'b1, 16'h0102, 16'h0304, 8'h05, 8'h06, 8'h07, 1'b0, 1'b0);
        do_return(16'h0077, 16'hC000, 16'h0102, 16'h0304, 8'h05, 8'h06, 8'h07, 1'b0);
        round(16'h0004, 1'b0, 1'b0, 1'b1);   // R4/R6 wrap below zero, R8 late commands
        round(16'hFFFF, 1'b1, 1'b1, 1'b0);   // R9 simultaneous commands
        round(16'h0008, 1'b1, 1'b1, 1'b1);

        for (int n = 0; n < 24; n++)
            round(16'($urandom), 1'($urandom), 1'($urandom), 1'($urandom));

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule